// File: doc/BRIEF.md
# Bank-Local Two-Way Cache Controller

This controller sits in front of a single backing memory bank. It takes read and write requests from an on-chip network through a valid/ready port. Every request is looked up first in a small local two-way set-associative cache. A hit is answered straight from the cache as a response packet. On a miss, the controller reads the whole cache line from the bank in one wide access, installs it, and then answers as if the request had hit. If the chosen victim line is dirty, the controller first writes the full line back to the bank.

The cache has one shared port, so only one request is in service at a time. While a request is being served, the request port deasserts ready until the response has been taken. The backing bank is a behavioural line-wide memory. Its access time is a fixed bank latency plus a constant cell time. Each response carries the identifier of its request, so the requester can match replies.

Top module: `bankcache_top`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspValid` is 0, and every cache line is invalid.
- R2: A request that hits raises `rspValid` exactly 1 clock edge after the edge on which it was accepted, with no bank access.
- R3: Word addresses split into offset `[OFF_W-1:0]`, set index above the offset, and tag in the top bits; the defaults give offset [1:0], index [3:2], tag [7:4]. After reset, the bank word at address a holds `INIT_PATTERN ^ a` (0x5A00 ^ a by default), and a read returns the current word at its address.
- R4: A miss with a clean or invalid victim fetches the whole line in one bank access. It raises `rspValid` L+3 edges after acceptance, where L = BANK_LAT + CELL_LAT. The other words of that line then hit.
- R5: Two lines with the same set index and different tags are held at the same time, one per way.
- R6: Each set keeps one LRU bit. A miss replaces the least recently used way, and a hit or fill makes the accessed way most recently used.
- R7: A write hit updates the cached word and marks the line dirty. A miss whose victim is dirty writes the full victim line back before the fill, so `rspValid` rises 2L+4 edges after acceptance, and the written data survives eviction.
- R8: From acceptance until the response is taken, `reqReady` stays 0.
- R9: While `rspValid` is 1 and `rspReady` is 0, `rspValid`, `rspData` and `rspId` hold their values.
- R10: `rspId` equals the accepted `reqId`. A read response carries the addressed word, and a write response carries the word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller accepts a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | WORD_W | Write data |
| reqId | input | ID_W | Requester tag, returned in the response |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Requester takes the response |
| rspData | output | WORD_W | Read word, or written word for writes |
| rspId | output | ID_W | Tag of the request being answered |

## Verification
The bench measures the gap from acceptance to response for each request. A controller that went to the bank on a hit, refetched a line it already held, or skipped a writeback then shows the wrong gap. Three tags are pushed through one set so that the LRU bit has to spare the most recently touched line; a stuck or inverted LRU bit evicts the wrong way and turns an expected hit into a miss. A dirty line is evicted and read back, which exposes a lost writeback as stale data. Full sweeps of reads, writes and read-back over the whole address space cover every set and tag. They compare against a word-level model, so a wrong offset slice or a write that lands in the wrong way shows up as a data mismatch.

// File: rtl/bankcache_pkg.sv
package bankcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL,
    ST_RESP
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;    // latch the accepted request
    logic accessHit;     // perform the hit access, update LRU, load response
    logic installLine;   // write the fetched line into the victim way
    logic bankWriteSel;  // bank address selects the victim line (writeback)
  } dpStrobe_t;

endpackage

// File: rtl/bankcache_bank.sv
module bankcache_bank #(
  parameter int          LADDR_W      = 6,
  parameter int          WORD_W       = 16,
  parameter int          LINE_WORDS   = 4,
  parameter int          BANK_LAT     = 3,
  parameter int          CELL_LAT     = 2,
  parameter int unsigned INIT_PATTERN = 'h5A00
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bankStart,
  input  logic                         bankWrite,
  input  logic [LADDR_W-1:0]           bankLineAddr,
  input  logic [WORD_W*LINE_WORDS-1:0] bankWrLine,
  output logic [WORD_W*LINE_WORDS-1:0] bankRdLine,
  output logic                         bankBusy,
  output logic                         bankDone
);
  localparam int LINE_W    = WORD_W * LINE_WORDS;
  localparam int LINES     = 1 << LADDR_W;
  localparam int TOTAL_LAT = BANK_LAT + CELL_LAT;
  localparam int CNT_W     = $clog2(TOTAL_LAT + 1);

  logic [LINE_W-1:0]  mem [LINES];
  logic [CNT_W-1:0]   cnt;
  logic               opWrite;
  logic [LADDR_W-1:0] opAddr;
  logic [LINE_W-1:0]  opLine;

  always_ff @(posedge clk) begin
    if (rst) begin
      bankBusy <= 1'b0;
      bankDone <= 1'b0;
      cnt      <= '0;
      for (int l = 0; l < LINES; l++)
        for (int w = 0; w < LINE_WORDS; w++)
          mem[l][w*WORD_W +: WORD_W] <= WORD_W'(INIT_PATTERN ^ (l * LINE_WORDS + w));
    end else begin
      bankDone <= 1'b0;
      if (bankStart) begin
        bankBusy <= 1'b1;
        cnt      <= CNT_W'(TOTAL_LAT - 1);
      end else if (bankBusy) begin
        if (cnt == '0) begin
          bankBusy <= 1'b0;
          bankDone <= 1'b1;
          if (opWrite) mem[opAddr] <= opLine;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bankStart) begin
      opWrite <= bankWrite;
      opAddr  <= bankLineAddr;
      opLine  <= bankWrLine;
    end
    if (bankBusy && cnt == '0 && !opWrite) bankRdLine <= mem[opAddr];
  end

  // R4: completion only ends an access that was in flight
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    bankDone |-> (!bankBusy && $past(bankBusy)))
    else $error("bank done without a pending access");

endmodule

// File: rtl/bankcache_ctrl.sv
module bankcache_ctrl
  import bankcache_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      bankBusy,
  input  logic      bankDone,
  output logic      bankStart,
  output logic      bankWrite,
  output dpStrobe_t strobe
);
  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    bankStart = 1'b0;
    bankWrite = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.captureReq = 1'b1;
        nextState = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (hit) begin
          strobe.accessHit = 1'b1;
          nextState = ST_RESP;
        end else if (victimDirty) begin
          bankStart = 1'b1;
          bankWrite = 1'b1;
          strobe.bankWriteSel = 1'b1;
          nextState = ST_WB;
        end else begin
          bankStart = 1'b1;
          nextState = ST_FILL;
        end
      end
      ST_WB: if (bankDone) begin
        bankStart = 1'b1;
        nextState = ST_FILL;
      end
      ST_FILL: if (bankDone) begin
        strobe.installLine = 1'b1;
        nextState = ST_LOOKUP;
      end
      ST_RESP: if (rspReady) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);

  // R4: a new bank access never starts while one is in flight
  p_start_when_free_r4: assert property (@(posedge clk) disable iff (rst)
    bankStart |-> !bankBusy)
    else $error("bank started while busy");

  // R7: a line is written back only when the victim is dirty
  p_wb_only_dirty_r7: assert property (@(posedge clk) disable iff (rst)
    (bankStart && bankWrite) |-> victimDirty)
    else $error("writeback of a clean victim");

endmodule

// File: rtl/bankcache_dp.sv
module bankcache_dp
  import bankcache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WORD_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 4,
  parameter int ID_W       = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  dpStrobe_t                                     strobe,
  input  logic                                          reqWrite,
  input  logic [ADDR_W-1:0]                             reqAddr,
  input  logic [WORD_W-1:0]                             reqData,
  input  logic [ID_W-1:0]                               reqId,
  output logic                                          hit,
  output logic                                          victimDirty,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]          bankLineAddr,
  output logic [WORD_W*LINE_WORDS-1:0]                  bankWrLine,
  input  logic [WORD_W*LINE_WORDS-1:0]                  bankRdLine,
  output logic [WORD_W-1:0]                             rspData,
  output logic [ID_W-1:0]                               rspId
);
  localparam int WAYS   = 2;
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;

  logic                curWrite;
  logic [ADDR_W-1:0]   curAddr;
  logic [WORD_W-1:0]   curData;
  logic [ID_W-1:0]     curId;
  logic [OFF_W-1:0]    curOff;
  logic [IDX_W-1:0]    curIdx;
  logic [TAG_W-1:0]    curTag;

  logic [SETS-1:0]     validBits [WAYS];
  logic [SETS-1:0]     dirtyBits [WAYS];
  logic [SETS-1:0]     lruBits;          // per set: way to replace next
  logic [TAG_W-1:0]    tagArr    [WAYS][SETS];
  logic [LINE_W-1:0]   dataArr   [WAYS][SETS];

  logic [WAYS-1:0]     hitVec;
  logic                hitWay;
  logic                victimWay;
  logic [LINE_W-1:0]   hitLine;

  assign curOff = curAddr[OFF_W-1:0];
  assign curIdx = curAddr[OFF_W +: IDX_W];
  assign curTag = curAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validBits[w][curIdx] && (tagArr[w][curIdx] == curTag);
  end

  assign hit         = |hitVec;
  assign hitWay      = hitVec[1];
  assign victimWay   = lruBits[curIdx];
  assign victimDirty = validBits[victimWay][curIdx] && dirtyBits[victimWay][curIdx];
  assign hitLine     = dataArr[hitWay][curIdx];
  assign bankWrLine  = dataArr[victimWay][curIdx];
  assign bankLineAddr = strobe.bankWriteSel ? {tagArr[victimWay][curIdx], curIdx}
                                            : {curTag, curIdx};

  // State bits (reset)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) begin
        validBits[w] <= '0;
        dirtyBits[w] <= '0;
      end
      lruBits <= '0;
    end else begin
      if (strobe.installLine) begin
        validBits[victimWay][curIdx] <= 1'b1;
        dirtyBits[victimWay][curIdx] <= 1'b0;
      end
      if (strobe.accessHit) begin
        lruBits[curIdx] <= ~hitWay;
        if (curWrite) dirtyBits[hitWay][curIdx] <= 1'b1;
      end
    end
  end

  // Request, tag, data and response registers (no reset needed)
  always_ff @(posedge clk) begin
    if (strobe.captureReq) begin
      curWrite <= reqWrite;
      curAddr  <= reqAddr;
      curData  <= reqData;
      curId    <= reqId;
    end
    if (strobe.installLine) begin
      tagArr[victimWay][curIdx]  <= curTag;
      dataArr[victimWay][curIdx] <= bankRdLine;
    end
    if (strobe.accessHit) begin
      if (curWrite) dataArr[hitWay][curIdx][curOff*WORD_W +: WORD_W] <= curData;
      rspData <= curWrite ? curData : hitLine[curOff*WORD_W +: WORD_W];
      rspId   <= curId;
    end
  end

  // R5: a line is never held in both ways
  p_single_way_hit_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitVec))
    else $error("line present in two ways");

  // R4: a fill only installs a line that was missing
  p_fill_only_on_miss_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.installLine |-> !hit)
    else $error("fill of a line already present");

endmodule

// File: rtl/bankcache_top.sv
module bankcache_top
  import bankcache_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          WORD_W       = 16,
  parameter int          LINE_WORDS   = 4,
  parameter int          SETS         = 4,
  parameter int          ID_W         = 4,
  parameter int          BANK_LAT     = 3,
  parameter int          CELL_LAT     = 2,
  parameter int unsigned INIT_PATTERN = 'h5A00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  input  logic [ID_W-1:0]   reqId,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [WORD_W-1:0] rspData,
  output logic [ID_W-1:0]   rspId
);
  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int LINE_W  = WORD_W * LINE_WORDS;

  dpStrobe_t          strobe;
  logic               hit, victimDirty;
  logic               bankStart, bankWrite, bankBusy, bankDone;
  logic [LADDR_W-1:0] bankLineAddr;
  logic [LINE_W-1:0]  bankWrLine, bankRdLine;

  bankcache_ctrl i_ctrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .hit(hit), .victimDirty(victimDirty),
    .bankBusy(bankBusy), .bankDone(bankDone),
    .bankStart(bankStart), .bankWrite(bankWrite),
    .strobe(strobe)
  );

  bankcache_dp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
    .SETS(SETS), .ID_W(ID_W)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData), .reqId(reqId),
    .hit(hit), .victimDirty(victimDirty),
    .bankLineAddr(bankLineAddr), .bankWrLine(bankWrLine), .bankRdLine(bankRdLine),
    .rspData(rspData), .rspId(rspId)
  );

  bankcache_bank #(
    .LADDR_W(LADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
    .BANK_LAT(BANK_LAT), .CELL_LAT(CELL_LAT), .INIT_PATTERN(INIT_PATTERN)
  ) i_bank (
    .clk(clk), .rst(rst),
    .bankStart(bankStart), .bankWrite(bankWrite),
    .bankLineAddr(bankLineAddr), .bankWrLine(bankWrLine),
    .bankRdLine(bankRdLine), .bankBusy(bankBusy), .bankDone(bankDone)
  );

  // R9: a pending response is held until taken
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspId)))
    else $error("response changed before it was taken");

endmodule

// File: tb/test_bankcache_top.sv
module test_bankcache_top;
  localparam int BANK_LAT = 3;
  localparam int CELL_LAT = 2;
  localparam int L        = BANK_LAT + CELL_LAT;
  localparam int NWORDS   = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, rspReady = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [3:0]  reqId = '0;
  logic        reqReady, rspValid;
  logic [15:0] rspData;
  logic [3:0]  rspId;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [15:0] mirror [NWORDS];

  always #10 clk = ~clk;

  bankcache_top #(.BANK_LAT(BANK_LAT), .CELL_LAT(CELL_LAT)) i_bankcache_top (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData), .reqId(reqId),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspId(rspId));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expLat < 0: latency not checked; hold: cycles to delay rspReady
  task automatic doReq(input bit wr, input int addr, input logic [15:0] d,
                       input logic [3:0] id, input int expLat, input int hold,
                       input string req);
    int n;
    bit readyLeak;
    logic [15:0] expData;
    logic [15:0] heldData;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = 8'(addr); reqData = d; reqId = id;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    readyLeak = 0;
    while (!rspValid) begin
      if (reqReady) readyLeak = 1;
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    if (reqReady) readyLeak = 1;
    if (wr) mirror[addr] = d;
    expData = mirror[addr];
    check(!readyLeak, "R8", "reqReady while busy", int'(readyLeak), 0);
    if (expLat >= 0) check(n == expLat, req, "latency", n, expLat);
    if (hold > 0) begin
      heldData = rspData;
      repeat (hold) @(negedge clk);
      check(rspValid && rspData == heldData, "R9", "held response",
            int'(rspData), int'(heldData));
    end
    check(rspData == expData, wr ? "R10" : "R3", "data", int'(rspData), int'(expData));
    check(rspId == id, "R10", "id", int'(rspId), int'(id));
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < NWORDS; a++) mirror[a] = 16'h5A00 ^ 16'(a);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(rspValid == 1'b0, "R1", "rspValid after reset", int'(rspValid), 0);

    // R4 cold miss, then rest of the line hits (R2)
    doReq(0, 8'h00, 0, 4'h1, L + 3, 0, "R4");
    doReq(0, 8'h03, 0, 4'h2, 1, 0, "R2");
    // R5 second tag in set 0
    doReq(0, 8'h10, 0, 4'h3, L + 3, 0, "R4");
    doReq(0, 8'h00, 0, 4'h4, 1, 2, "R5");
    // R6 third tag evicts LRU line 0x10, line 0x00 survives
    doReq(0, 8'h20, 0, 4'h5, L + 3, 0, "R6");
    doReq(0, 8'h01, 0, 4'h6, 1, 0, "R6");
    doReq(0, 8'h11, 0, 4'h7, L + 3, 0, "R6");
    // R7 dirty line in set 1 evicted with writeback
    doReq(1, 8'h04, 16'hBEEF, 4'h8, L + 3, 0, "R7");
    doReq(1, 8'h05, 16'h1111, 4'h9, 1, 0, "R7");
    doReq(0, 8'h14, 0, 4'hA, L + 3, 0, "R7");
    doReq(0, 8'h24, 0, 4'hB, 2 * L + 4, 0, "R7");
    doReq(0, 8'h04, 0, 4'hC, L + 3, 3, "R7");
    doReq(0, 8'h05, 0, 4'hD, 1, 0, "R7");

    // Sweeps over the whole address space (R3, R7, R10)
    for (int a = 0; a < NWORDS; a++) doReq(0, a, 0, 4'(a), -1, 0, "R3");
    for (int a = 0; a < NWORDS; a++)
      doReq(1, a, 16'(a * 37) ^ 16'hC3C3, 4'(a + 5), -1, 0, "R10");
    for (int a = NWORDS - 1; a >= 0; a--) doReq(0, a, 0, 4'(a + 9), -1, 0, "R7");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule